// File: doc/BRIEF.md
# Fixed-Point 8x8 Separable DCT Engine

This block takes an 8x8 tile of signed pixels, already shifted down so that they sit around zero, and returns the 64 coefficients of its two-dimensional discrete cosine transform. The arithmetic is integer only. The 2D transform is split into two 1D passes: the rows are transformed first, then the columns.

Eight multiply-accumulate lanes run side by side. Each cycle one operand is broadcast to all eight lanes. Every lane multiplies that operand by its own entry of a shared 64-entry cosine table and adds the product to a 32-bit running sum. After eight such cycles the eight lanes together hold one complete 1D transform.

The row results are rounded and written into a transpose store. The column pass reads that store back one column at a time and runs the same eight lanes over it. Each finished column of eight coefficients is then sent out over a valid/ready stream.

Top module: `dct8x8_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `in_ready` is 1 and `out_valid` is 0.
- R2: The cosine table entry for frequency k and sample n (both 0 to 7) is 724 when k is 0, and round(1024*cos((2n+1)k*pi/16)) when k is 1 or more. Each entry is a 12-bit signed value. For example, the entry for k=1, n=0 is 1004.
- R3: Row pass: the intermediate value T[r][k] equals (sum over n of x[r][n]*C[k][n] + 1024) >>> 11. Here C is the table of R2 and >>> is an arithmetic (flooring) shift. The result is kept as 16-bit signed and never overflows for 8-bit inputs.
- R4: Column pass: the coefficient F[v][u] equals (sum over r of T[r][u]*C[v][r] + 1024) >>> 11, given as 16-bit signed. Output j of a block carries F[v][u] with u = j/8 and v = j%8, so the outer loop is over columns and the inner loop over vertical frequency.
- R5: `in_ready` is 0 from the cycle after the 64th input sample is accepted until the 64th output of that block is accepted. It is 1 again in the cycle after that. `in_ready` and `out_valid` are never high in the same cycle.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value in the next cycle.
- R7: Input samples are taken in raster order: sample j is row j/8, column j%8. Cycles with `in_valid` low leave the result unchanged.
- R8: Inputs are 8-bit two's complement, from -128 to 127. Blocks at the extremes of this range, such as full-scale constants and full-scale checkerboards, give exactly the results of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_ready | output | 1 | Engine accepts an input sample |
| in_data | input | 8 | Level-shifted signed pixel |
| out_valid | output | 1 | Output coefficient is present |
| out_ready | input | 1 | Consumer accepts the coefficient |
| out_data | output | 16 | Signed DCT coefficient |

## Verification
Each of the 64 single-pixel impulse positions is swept, with alternating signs. This exposes a table entry with the wrong sign or value, and an index that takes the row order where the column order belongs: either fault sends energy to the wrong coefficient. Full-scale constants and checkerboards at -128 and 127 test the flooring rounding and the 16-bit intermediate width. A truncating shift would be off by one on negative values, and a narrow store would wrap the DC term. Pseudo-random blocks run with input gaps and output backpressure. A lane that accumulates on an idle cycle, or an output register that shifts while stalled, would then produce a shifted or duplicated coefficient sequence.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Quantised cosine of m*pi/16 for m = 0..7, scaled by 1024.
  function automatic int cos_q(input int m);
    case (m)
      0: return 1024;
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  // Table entry for frequency k, sample n; DC row carries the 1/sqrt(2) fold.
  function automatic int coef_val(input int k, input int n);
    int m;
    if (k == 0) return 724;
    m = ((2 * n + 1) * k) % 32;
    if (m > 16) m = 32 - m;
    if (m < 8) return cos_q(m);
    if (m == 8) return 0;
    return -cos_q(16 - m);
  endfunction

  typedef enum logic [1:0] {ST_ROW, ST_COL, ST_OUT} dct_state_t;

endpackage

// File: rtl/dct_mac.sv
module dct_mac #(
  parameter int X_W    = 16,
  parameter int COEF_W = 12,
  parameter int ACC_W  = 32,
  parameter int N      = 8,
  parameter int K      = 0,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [X_W-1:0]    x,
  input  logic [IDX_W-1:0]         sel,
  output logic signed [ACC_W-1:0]  acc
);
  import dct_pkg::*;

  localparam int P_W = X_W + COEF_W;

  logic signed [COEF_W-1:0] row_c [N];
  logic signed [COEF_W-1:0] coef;
  logic signed [P_W-1:0]    prod;
  logic signed [ACC_W-1:0]  base;

  // This lane's row of the shared cosine table.
  for (genvar n = 0; n < N; n++) begin : g_rom
    assign row_c[n] = COEF_W'(coef_val(K, n));
  end

  assign coef = row_c[sel];
  assign prod = x * coef;
  // The first term of a group starts from zero.
  assign base = (sel == '0) ? '0 : acc;

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= base + ACC_W'(prod);
  end

endmodule

// File: rtl/dct_tbuf.sv
module dct_tbuf #(
  parameter int N     = 8,
  parameter int MID_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    w_en,
  input  logic [IDX_W-1:0]        w_addr,
  input  logic signed [MID_W-1:0] w_data [N],
  input  logic [IDX_W-1:0]        r_addr,
  input  logic [IDX_W-1:0]        r_bank,
  output logic signed [MID_W-1:0] r_data
);
  logic signed [MID_W-1:0] bank_q [N];
  logic [IDX_W-1:0]        bank_sel;

  // One small RAM per frequency lane, addressed by the source row.
  for (genvar b = 0; b < N; b++) begin : g_bank
    logic signed [MID_W-1:0] mem [N];
    always_ff @(posedge clk) begin
      if (w_en) mem[w_addr] <= w_data[b];
      bank_q[b] <= mem[r_addr];
    end
  end

  always_ff @(posedge clk) bank_sel <= r_bank;

  assign r_data = bank_q[bank_sel];

endmodule

// File: rtl/dct8x8_core.sv
module dct8x8_core #(
  parameter int IN_W   = 8,
  parameter int COEF_W = 12,
  parameter int ACC_W  = 32,
  parameter int MID_W  = 16,
  parameter int OUT_W  = 16,
  parameter int FRAC   = 10,
  parameter int N      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  import dct_pkg::*;

  localparam int IDX_W = $clog2(N);
  localparam int NN    = N * N;
  localparam int SMP_W = $clog2(NN);
  localparam int CNT_W = IDX_W + 1;
  localparam int SH    = FRAC + 1;
  localparam int HALF  = 1 << (SH - 1);

  dct_state_t              state;
  logic [SMP_W-1:0]        smp_cnt;
  logic [CNT_W-1:0]        cnt;
  logic [IDX_W-1:0]        col_u, rd_row, wr_row, out_cnt;
  logic                    rd_v, wr_pend, take_in;
  logic signed [MID_W-1:0] rd_q;
  logic signed [MID_W-1:0] mac_x;
  logic [IDX_W-1:0]        mac_sel;
  logic                    mac_en;
  logic signed [ACC_W-1:0] acc      [N];
  logic signed [ACC_W-1:0] row_wide [N];
  logic signed [ACC_W-1:0] col_wide [N];
  logic signed [MID_W-1:0] row_val  [N];
  logic [OUT_W-1:0]        out_sh   [N];

  assign in_ready = (state == ST_ROW);
  assign take_in  = in_valid && in_ready;
  assign out_data = out_sh[0];

  // Operand and table column: input samples in the row pass, store reads in the column pass.
  assign mac_en  = take_in || rd_v;
  assign mac_x   = (state == ST_ROW) ? MID_W'($signed(in_data)) : rd_q;
  assign mac_sel = (state == ST_ROW) ? smp_cnt[IDX_W-1:0] : rd_row;

  for (genvar k = 0; k < N; k++) begin : g_lane
    dct_mac #(.X_W(MID_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .N(N), .K(k)) u_mac (
      .clk(clk), .rst(rst), .en(mac_en), .x(mac_x), .sel(mac_sel), .acc(acc[k])
    );
    assign row_wide[k] = (acc[k] + ACC_W'(HALF)) >>> SH;
    assign col_wide[k] = (acc[k] + ACC_W'(HALF)) >>> SH;
    assign row_val[k]  = row_wide[k][MID_W-1:0];

    // R3: rounded row result fits the transpose store width.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
      wr_pend |-> (row_wide[k] == $signed(row_wide[k][MID_W-1:0])));
    // R4: rounded column result fits the output width when loaded.
    assert_col_range_R4: assert property (@(posedge clk) disable iff (rst)
      (state == ST_COL && cnt == CNT_W'(N + 1)) |-> (col_wide[k] == $signed(col_wide[k][OUT_W-1:0])));
  end

  dct_tbuf #(.N(N), .MID_W(MID_W)) u_tbuf (
    .clk(clk), .w_en(wr_pend), .w_addr(wr_row), .w_data(row_val),
    .r_addr(cnt[IDX_W-1:0]), .r_bank(col_u), .r_data(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ROW;
      smp_cnt   <= '0;
      cnt       <= '0;
      col_u     <= '0;
      rd_row    <= '0;
      rd_v      <= 1'b0;
      wr_pend   <= 1'b0;
      wr_row    <= '0;
      out_cnt   <= '0;
      out_valid <= 1'b0;
      for (int i = 0; i < N; i++) out_sh[i] <= '0;
    end else begin
      wr_pend <= 1'b0;
      rd_v    <= (state == ST_COL) && (cnt < CNT_W'(N));
      rd_row  <= cnt[IDX_W-1:0];
      case (state)
        ST_ROW: if (take_in) begin
          smp_cnt <= smp_cnt + 1'b1;
          if (smp_cnt[IDX_W-1:0] == IDX_W'(N - 1)) begin
            wr_pend <= 1'b1;
            wr_row  <= smp_cnt[SMP_W-1:IDX_W];
          end
          if (smp_cnt == SMP_W'(NN - 1)) begin
            state <= ST_COL;
            cnt   <= '0;
            col_u <= '0;
          end
        end
        ST_COL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(N + 1)) begin
            for (int i = 0; i < N; i++) out_sh[i] <= col_wide[i][OUT_W-1:0];
            out_valid <= 1'b1;
            out_cnt   <= '0;
            state     <= ST_OUT;
          end
        end
        default: if (out_ready) begin
          for (int i = 0; i < N - 1; i++) out_sh[i] <= out_sh[i + 1];
          out_cnt <= out_cnt + 1'b1;
          if (out_cnt == IDX_W'(N - 1)) begin
            out_valid <= 1'b0;
            cnt       <= '0;
            if (col_u == IDX_W'(N - 1)) state <= ST_ROW;
            else begin
              col_u <= col_u + 1'b1;
              state <= ST_COL;
            end
          end
        end
      endcase
    end
  end

  // R5: the two streams are never open at once.
  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
  // R5: input reopens right after the final coefficient of a block leaves.
  assert_reopen_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_cnt == IDX_W'(N - 1) && col_u == IDX_W'(N - 1)) |=> in_ready);
  // R6: a stalled coefficient is held.
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/sim_dct8x8_core.sv
module sim_dct8x8_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  int cf [8][8];
  int pix [64];
  int expv [64];
  int seed = 32'h1234567;

  dct8x8_core u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int rnd_real(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int rsh(input longint s);
    longint t;
    t = (s + 64'sd1024) >>> 11;
    return int'(t);
  endfunction

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic build_model();
    int t [8][8];
    for (int r = 0; r < 8; r++)
      for (int k = 0; k < 8; k++) begin
        longint s = 0;
        for (int n = 0; n < 8; n++) s += longint'(pix[r*8+n]) * cf[k][n];
        t[r][k] = rsh(s);
      end
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        longint s = 0;
        for (int r = 0; r < 8; r++) s += longint'(t[r][u]) * cf[v][r];
        expv[u*8+v] = rsh(s);
      end
  endtask

  task automatic send_block(input bit gaps);
    int i = 0;
    int t = 0;
    while (i < 64) begin
      @(negedge clk);
      t++;
      in_valid = !(gaps && (t % 3 == 0));
      in_data  = 8'(pix[i]);
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_block(input string req, input bit bp);
    int j = 0;
    int t = 0;
    bit stalled = 0;
    bit both = 0;
    int held = 0;
    while (j < 64) begin
      @(negedge clk);
      t++;
      if (stalled) begin
        check("R6 held valid", int'(out_valid), 1);
        check("R6 held data", int'(out_data), held);
      end
      if (in_ready && out_valid) both = 1;
      out_ready = bp ? ((t % 5) >= 2) : 1'b1;
      if (out_valid && out_ready) begin
        check(req, int'($signed(out_data)), expv[j]);
        j++;
      end
      stalled = out_valid && !out_ready;
      held    = int'(out_data);
    end
    check("R5 no overlap", int'(both), 0);
    @(negedge clk);
    check("R5 reopen", int'(in_ready), 1);
    out_ready = 1'b1;
  endtask

  task automatic run_block(input string req, input bit gaps, input bit bp);
    build_model();
    fork
      send_block(gaps);
      recv_block(req, bp);
    join
  endtask

  initial begin
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 8; n++)
        if (k == 0) cf[k][n] = rnd_real(1024.0 / $sqrt(2.0));
        else cf[k][n] = rnd_real(1024.0 * $cos((2*n+1) * k * 3.14159265358979 / 16.0));

    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 1);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);

    // R3: all-zero block
    for (int i = 0; i < 64; i++) pix[i] = 0;
    run_block("R3 zero block", 0, 0);
    // R2: DC scaling through the k=0 entry
    for (int i = 0; i < 64; i++) pix[i] = 10;
    run_block("R2 constant block", 0, 0);
    // R8: full-scale extremes
    for (int i = 0; i < 64; i++) pix[i] = -128;
    run_block("R8 min constant", 0, 0);
    for (int i = 0; i < 64; i++) pix[i] = 127;
    run_block("R8 max constant", 0, 1);
    for (int i = 0; i < 64; i++) pix[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 127 : -128;
    run_block("R8 checkerboard", 1, 1);
    // R4: every impulse position, alternating sign
    for (int p = 0; p < 64; p++) begin
      for (int i = 0; i < 64; i++) pix[i] = 0;
      pix[p] = (p % 2 == 0) ? 100 : -100;
      run_block("R4 impulse", 0, (p % 4 == 3));
    end
    // R7: pseudo-random blocks with input gaps and output backpressure
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 64; i++) begin
        seed = seed * 1103515245 + 12345;
        pix[i] = ((seed >>> 16) & 255) - 128;
      end
      run_block("R7 random with gaps", 1, b[0]);
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule